// File: doc/BRIEF.md
# SONET Transport Overhead Generator

This block completes an outgoing STS-1 or STS-3 frame. It takes a byte-interleaved stream of one byte per clock, with a marker on the first byte of each frame. It replaces the section and line overhead positions with framing, trace, parity, protection, synchronization-status, remote-error and user-channel bytes. It then applies the frame-synchronous scrambler, and the result is ready for serialization. Pointer bytes and payload columns pass through from the input.

Parity is computed in the block itself. The section parity byte is a bit-interleaved parity over the whole previous frame as transmitted. The line parity bytes give one parity value per constituent STS-1, taken over the previous frame before scrambling, with the first three overhead rows excluded. Test controls can corrupt the section parity for a single frame, corrupt the framing pattern, or force line AIS. A single control bit sets the fill value for every inhibited or unused overhead byte.

The frame has 9 rows of 90·N columns, sent row by row. Overhead column group g (0, 1 or 2) takes columns g·N to g·N+N-1. Within a group, column offset s belongs to STS-1 number s. N is 1 or 3.

Top module: `toh_generator`

## Requirements
- R1: In row 0, columns 0..N-1 carry 0xF6 and columns N..2N-1 carry 0x28. These bytes are never scrambled, and `out_sof` marks the first 0xF6.
- R2: Row 0 column 2N carries `j0_val` when `ins_en[5]` is 1 and the fill value otherwise. Row 0 columns 2N+1..3N-1 carry the fill value. None of these bytes is scrambled.
- R3: Every byte outside row 0 columns 0..3N-1 is XORed with the output of the x^7+x^6+1 generator, taken MSB first. The generator is set to all ones at row 0 column 3N, so that byte's mask is 0xFE. It then advances one byte per byte to the end of the frame.
- R4: Row 3 columns 0..3N-1 (pointer bytes) and all columns from 3N upward carry `in_byte` before scrambling.
- R5: When its enable bit is 1, each field is inserted at its position as follows:
  - `k1_val` (bit 0) at row 4 column N.
  - `k2_val` (bit 1) at row 4 column 2N.
  - `s1_val` (bit 2) at row 8 column 0.
  - `rei_val` (bit 3) at row 8 column 2N-1.
  - `f1_val` (bit 4) at row 1 column 2N.
- R6: When a field's enable bit is 0, its byte is 0xFF if `fill_ones` is 1 and 0x00 otherwise. The same fill goes into every overhead byte that has no assigned field.
- R7: Row 1 column 0 carries the XOR of all output bytes of the previous frame, and 0x00 in the first frame after reset.
- R8: Row 4 column k (k < N) carries the XOR of the previous frame's pre-scramble bytes of STS-1 k, that is columns c with c mod N = k. Rows 0..2 columns 0..3N-1 are excluded, and the value is 0x00 after reset.
- R9: A one-cycle `b1_err_req` pulse inverts all 8 bits of the next row 1 column 0 byte (before scrambling). It affects only that single frame.
- R10: While `a2_err` is 1, the byte at row 0 column N is 0x29 instead of 0x28, and the other 0x28 bytes are unchanged.
- R11: While `ais_line` is 1, every byte except rows 0..2 columns 0..3N-1 is 0xFF before scrambling.
- R12: `out_byte` and `out_sof` show the byte presented one clock earlier. Both are 0 during and right after synchronous reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| in_byte | input | 8 | Interleaved payload and pointer stream |
| in_sof | input | 1 | High on the first byte of each frame |
| k1_val | input | 8 | Protection byte 1 value |
| k2_val | input | 8 | Protection byte 2 value |
| s1_val | input | 8 | Synchronization status value |
| rei_val | input | 8 | Line remote-error count byte |
| f1_val | input | 8 | Section user channel value |
| j0_val | input | 8 | Section trace value |
| ins_en | input | 6 | Insert enables: 0 K1, 1 K2, 2 S1, 3 REI, 4 F1, 5 trace |
| fill_ones | input | 1 | Fill value select: 1 gives 0xFF, 0 gives 0x00 |
| ais_line | input | 1 | Force line AIS |
| b1_err_req | input | 1 | Pulse: corrupt the next section parity byte |
| a2_err | input | 1 | Corrupt the first 0x28 framing byte |
| out_byte | output | 8 | Finished scrambled byte |
| out_sof | output | 1 | Marks first byte of an output frame |

## Verification
The hardest cases to reach are the parity bytes that follow an unusual frame: a B1 byte computed over a frame that itself carried a corrupted B1, and B2 bytes computed over a frame sent under line AIS. These cases only show up one frame after the cause. The stimulus therefore runs six back-to-back frames. An error pulse arrives mid-frame, the fill and enable settings change between frames, and an AIS frame is followed by normal frames. A bench reference model follows each byte in raster order, so the parity carried forward is checked at every frame boundary.

// File: rtl/toh_pkg.sv
package toh_pkg;

    localparam int ROWS = 9;
    localparam logic [7:0] A1_BYTE = 8'hF6;
    localparam logic [7:0] A2_BYTE = 8'h28;

    // insert enable bit positions
    localparam int EN_K1  = 0;
    localparam int EN_K2  = 1;
    localparam int EN_S1  = 2;
    localparam int EN_REI = 3;
    localparam int EN_F1  = 4;
    localparam int EN_J0  = 5;
    localparam int EN_W   = 6;

    typedef enum logic [3:0] {
        FLD_A1, FLD_A2, FLD_J0, FLD_Z0, FLD_B1, FLD_F1, FLD_PTR,
        FLD_B2, FLD_K1, FLD_K2, FLD_S1, FLD_REI, FLD_SPARE, FLD_PAY
    } fld_e;

    typedef struct packed {
        logic [7:0] mask;
        logic [6:0] nxt;
    } scr_t;

    typedef struct packed {
        logic [7:0] k1;
        logic [7:0] k2;
        logic [7:0] s1;
        logic [7:0] rei;
        logic [7:0] f1;
        logic [7:0] j0;
    } ohv_t;

    // Eight steps of the x^7+x^6+1 generator, first bit in the MSB.
    function automatic scr_t scr_advance(logic [6:0] s);
        scr_t r;
        logic [6:0] st;
        st = s;
        r.mask = '0;
        for (int i = 7; i >= 0; i--) begin
            r.mask[i] = st[6];
            st = {st[5:0], st[6] ^ st[5]};
        end
        r.nxt = st;
        return r;
    endfunction

    // Field at (row, col) of an STS-n frame.
    function automatic fld_e classify(int row, int col, int n);
        int   grp;
        int   sub;
        fld_e f;
        grp = col / n;
        sub = col % n;
        f   = FLD_SPARE;
        if (col >= 3 * n) begin
            f = FLD_PAY;
        end else begin
            case (row)
                0: f = (grp == 0) ? FLD_A1 : (grp == 1) ? FLD_A2 :
                       (sub == 0) ? FLD_J0 : FLD_Z0;
                1: if (sub == 0 && grp == 0) f = FLD_B1;
                   else if (sub == 0 && grp == 2) f = FLD_F1;
                3: f = FLD_PTR;
                4: if (grp == 0) f = FLD_B2;
                   else if (sub == 0 && grp == 1) f = FLD_K1;
                   else if (sub == 0 && grp == 2) f = FLD_K2;
                8: if (grp == 0 && sub == 0) f = FLD_S1;
                   else if (grp == 1 && sub == n - 1) f = FLD_REI;
                default: f = FLD_SPARE;
            endcase
        end
        return f;
    endfunction

endpackage

// File: rtl/toh_position.sv
module toh_position
    import toh_pkg::*;
#(
    parameter int COLS  = 270,
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sof,
    output logic [3:0]       row,
    output logic [COL_W-1:0] col,
    output logic             frame_end
);
    logic [3:0]       row_q;
    logic [COL_W-1:0] col_q;
    logic             col_last;
    logic             row_last;

    always_comb begin
        row       = sof ? '0 : row_q;
        col       = sof ? '0 : col_q;
        col_last  = (col == COL_W'(COLS - 1));
        row_last  = (row == 4'(ROWS - 1));
        frame_end = row_last && col_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
            col_q <= '0;
        end else if (col_last) begin
            col_q <= '0;
            row_q <= row_last ? '0 : row + 4'd1;
        end else begin
            col_q <= col + 1'b1;
        end
    end

    p_pos_range_r12: assert property (@(posedge clk) disable iff (rst)
        (row_q < 4'(ROWS)) && (col_q < COL_W'(COLS)));

endmodule

// File: rtl/toh_scrambler.sv
module toh_scrambler
    import toh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       adv,
    output logic [7:0] mask
);
    logic [6:0] state_q;
    logic [6:0] cur;
    scr_t       step;

    always_comb begin
        cur  = start ? 7'h7F : state_q;
        step = scr_advance(cur);
        mask = step.mask;
    end

    always_ff @(posedge clk) begin
        if (rst)      state_q <= 7'h7F;
        else if (adv) state_q <= step.nxt;
    end

    // A maximal-length generator seeded non-zero never reaches zero (R3)
    p_state_live_r3: assert property (@(posedge clk) disable iff (rst)
        state_q != 7'h00);

endmodule

// File: rtl/toh_parity.sv
module toh_parity #(
    parameter int N     = 3,
    parameter int STS_W = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [7:0]            pre_b,
    input  logic [7:0]            post_b,
    input  logic [STS_W-1:0]      sts,
    input  logic                  line_cov,
    input  logic                  frame_end,
    output logic [7:0]            b1_val,
    output logic [N-1:0][7:0]     b2_vals
);
    logic [7:0] b1_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            b1_acc <= '0;
            b1_val <= '0;
        end else if (frame_end) begin
            b1_val <= b1_acc ^ post_b;
            b1_acc <= '0;
        end else begin
            b1_acc <= b1_acc ^ post_b;
        end
    end

    for (genvar s = 0; s < N; s++) begin : g_line
        logic [7:0] acc;
        logic       hit;
        assign hit = line_cov && (sts == STS_W'(s));
        always_ff @(posedge clk) begin
            if (rst) begin
                acc        <= '0;
                b2_vals[s] <= '0;
            end else if (frame_end) begin
                b2_vals[s] <= acc ^ (hit ? pre_b : 8'h00);
                acc        <= '0;
            end else if (hit) begin
                acc <= acc ^ pre_b;
            end
        end
    end

    // Parity results only move at a frame boundary (R7)
    p_b1_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(b1_val));

endmodule

// File: rtl/toh_generator.sv
module toh_generator
    import toh_pkg::*;
#(
    parameter int N = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_byte,
    input  logic       in_sof,
    input  logic [7:0] k1_val,
    input  logic [7:0] k2_val,
    input  logic [7:0] s1_val,
    input  logic [7:0] rei_val,
    input  logic [7:0] f1_val,
    input  logic [7:0] j0_val,
    input  logic [5:0] ins_en,
    input  logic       fill_ones,
    input  logic       ais_line,
    input  logic       b1_err_req,
    input  logic       a2_err,
    output logic [7:0] out_byte,
    output logic       out_sof
);
    localparam int COLS    = 90 * N;
    localparam int OH_COLS = 3 * N;
    localparam int COL_W   = $clog2(COLS);
    localparam int STS_W   = (N > 1) ? $clog2(N) : 1;

    logic [3:0]           row;
    logic [COL_W-1:0]     col;
    logic                 frame_end;
    logic [STS_W-1:0]     sts;
    fld_e                 fld;
    ohv_t                 ohv;
    logic [7:0]           fill;
    logic [7:0]           pre_b;
    logic [7:0]           post_b;
    logic [7:0]           scr_mask;
    logic                 unscr;
    logic                 line_cov;
    logic                 scr_start;
    logic                 scr_adv;
    logic                 b1_apply;
    logic                 b1_pend_q;
    logic [7:0]           b1_val;
    logic [N-1:0][7:0]    b2_vals;

    toh_position #(.COLS(COLS), .COL_W(COL_W)) u_pos (
        .clk(clk), .rst(rst), .sof(in_sof),
        .row(row), .col(col), .frame_end(frame_end)
    );

    toh_scrambler u_scr (
        .clk(clk), .rst(rst), .start(scr_start), .adv(scr_adv), .mask(scr_mask)
    );

    toh_parity #(.N(N), .STS_W(STS_W)) u_par (
        .clk(clk), .rst(rst), .pre_b(pre_b), .post_b(post_b), .sts(sts),
        .line_cov(line_cov), .frame_end(frame_end),
        .b1_val(b1_val), .b2_vals(b2_vals)
    );

    assign ohv = '{k1: k1_val, k2: k2_val, s1: s1_val, rei: rei_val,
                   f1: f1_val, j0: j0_val};

    always_comb begin
        fill      = {8{fill_ones}};
        sts       = STS_W'(int'(col) % N);
        fld       = classify(int'(row), int'(col), N);
        unscr     = (row == 4'd0) && (int'(col) < OH_COLS);
        line_cov  = (row >= 4'd3) || (int'(col) >= OH_COLS);
        scr_start = (row == 4'd0) && (int'(col) == OH_COLS);
        scr_adv   = !unscr;
        b1_apply  = (fld == FLD_B1) && (b1_pend_q || b1_err_req);
        case (fld)
            FLD_A1:  pre_b = A1_BYTE;
            FLD_A2:  pre_b = A2_BYTE ^ {7'b0, a2_err && (int'(col) == N)};
            FLD_J0:  pre_b = ins_en[EN_J0]  ? ohv.j0  : fill;
            FLD_B1:  pre_b = b1_val ^ {8{b1_apply}};
            FLD_F1:  pre_b = ins_en[EN_F1]  ? ohv.f1  : fill;
            FLD_PTR: pre_b = in_byte;
            FLD_PAY: pre_b = in_byte;
            FLD_B2:  pre_b = b2_vals[sts];
            FLD_K1:  pre_b = ins_en[EN_K1]  ? ohv.k1  : fill;
            FLD_K2:  pre_b = ins_en[EN_K2]  ? ohv.k2  : fill;
            FLD_S1:  pre_b = ins_en[EN_S1]  ? ohv.s1  : fill;
            FLD_REI: pre_b = ins_en[EN_REI] ? ohv.rei : fill;
            default: pre_b = fill;
        endcase
        if (ais_line && line_cov) pre_b = 8'hFF;
        post_b = unscr ? pre_b : (pre_b ^ scr_mask);
    end

    always_ff @(posedge clk) begin
        if (rst)                  b1_pend_q <= 1'b0;
        else if (fld == FLD_B1)   b1_pend_q <= 1'b0;
        else if (b1_err_req)      b1_pend_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_byte <= '0;
            out_sof  <= 1'b0;
        end else begin
            out_byte <= post_b;
            out_sof  <= in_sof;
        end
    end

    p_frame_start_r1: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_byte == A1_BYTE);

    p_b1_insert_r7: assert property (@(posedge clk) disable iff (rst)
        (fld == FLD_B1 && !b1_apply && !ais_line) |=> out_byte == $past(b1_val ^ scr_mask));

    p_ais_fill_r11: assert property (@(posedge clk) disable iff (rst)
        (ais_line && line_cov) |=> out_byte == $past(8'hFF ^ scr_mask));

endmodule

// File: tb/sim_toh_generator.sv
module sim_toh_generator;
    localparam int N    = 3;
    localparam int COLS = 90 * N;
    localparam int OHC  = 3 * N;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_byte = '0;
    logic       in_sof = 1'b0;
    logic [7:0] k1_val = 8'h3C, k2_val = 8'hA5, s1_val = 8'h0F;
    logic [7:0] rei_val = 8'h07, f1_val = 8'h5A, j0_val = 8'h01;
    logic [5:0] ins_en = '0;
    logic       fill_ones = 1'b0, ais_line = 1'b0, b1_err_req = 1'b0, a2_err = 1'b0;
    logic [7:0] out_byte;
    logic       out_sof;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] q_val[$];
    logic       q_sof[$];
    string      q_tag[$];

    // reference model state
    logic [6:0] m_scr = 7'h7F;
    logic [7:0] m_b1 = '0, m_b1acc = '0;
    logic [7:0] m_b2 [N];
    logic [7:0] m_b2acc [N];
    logic       m_pend = 1'b0;

    always #4 clk = ~clk;

    toh_generator #(.N(N)) u0 (
        .clk(clk), .rst(rst), .in_byte(in_byte), .in_sof(in_sof),
        .k1_val(k1_val), .k2_val(k2_val), .s1_val(s1_val), .rei_val(rei_val),
        .f1_val(f1_val), .j0_val(j0_val), .ins_en(ins_en), .fill_ones(fill_ones),
        .ais_line(ais_line), .b1_err_req(b1_err_req), .a2_err(a2_err),
        .out_byte(out_byte), .out_sof(out_sof)
    );

    task automatic check(input bit ok, input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
        end
    endtask

    // monitor: pops one expected byte per clock
    always @(posedge clk) begin
        #2;
        if (q_val.size() > 0) begin
            logic [7:0] ev;
            logic       es;
            string      et;
            ev = q_val.pop_front();
            es = q_sof.pop_front();
            et = q_tag.pop_front();
            check(out_byte === ev, et, out_byte, ev);
            check(out_sof === es, "R12 sof", {7'b0, out_sof}, {7'b0, es});
        end
    end

    task automatic send_frame(input int f, input logic [5:0] en, input bit fl1,
                              input bit ais, input bit a2e, input int pulse_row);
        for (int r = 0; r < 9; r++) begin
            for (int c = 0; c < COLS; c++) begin
                logic [7:0] d, pre, post, fl, mask;
                int grp, sub;
                bit req, line;
                string tag;
                @(negedge clk);
                d   = 8'((f * 29 + r * 53 + c * 7) ^ (c >> 2));
                req = (r == pulse_row) && (c == 0);
                rst = 1'b0;
                in_sof = (r == 0 && c == 0);
                in_byte = d; ins_en = en; fill_ones = fl1;
                ais_line = ais; a2_err = a2e; b1_err_req = req;
                fl  = {8{fl1}};
                grp = c / N; sub = c % N;
                pre = fl; tag = "R6";
                if (c >= OHC) begin
                    pre = d; tag = "R3";
                end else begin
                    case (r)
                        0: begin
                            if (grp == 0) begin pre = 8'hF6; tag = "R1"; end
                            else if (grp == 1) begin
                                pre = (a2e && sub == 0) ? 8'h29 : 8'h28;
                                tag = (a2e && sub == 0) ? "R10" : "R1";
                            end else begin
                                pre = (sub == 0 && en[5]) ? j0_val : fl; tag = "R2";
                            end
                        end
                        1: begin
                            if (grp == 0 && sub == 0) begin
                                pre = (m_pend || req) ? ~m_b1 : m_b1;
                                tag = (m_pend || req) ? "R9" : "R7";
                                m_pend = 1'b0;
                            end else if (grp == 2 && sub == 0) begin
                                pre = en[4] ? f1_val : fl; tag = en[4] ? "R5" : "R6";
                            end
                        end
                        3: begin pre = d; tag = "R4"; end
                        4: begin
                            if (grp == 0) begin pre = m_b2[sub]; tag = "R8"; end
                            else if (grp == 1 && sub == 0) begin
                                pre = en[0] ? k1_val : fl; tag = en[0] ? "R5" : "R6";
                            end else if (grp == 2 && sub == 0) begin
                                pre = en[1] ? k2_val : fl; tag = en[1] ? "R5" : "R6";
                            end
                        end
                        8: begin
                            if (grp == 0 && sub == 0) begin
                                pre = en[2] ? s1_val : fl; tag = en[2] ? "R5" : "R6";
                            end else if (grp == 1 && sub == N - 1) begin
                                pre = en[3] ? rei_val : fl; tag = en[3] ? "R5" : "R6";
                            end
                        end
                        default: ;
                    endcase
                end
                if (req && !(r == 1 && c == 0)) m_pend = 1'b1;
                line = (r >= 3) || (c >= OHC);
                if (ais && line) begin pre = 8'hFF; tag = "R11"; end
                if (r == 0 && c == OHC) m_scr = 7'h7F;
                if (r == 0 && c < OHC) post = pre;
                else begin
                    mask = '0;
                    for (int b = 0; b < 8; b++) begin
                        mask = {mask[6:0], m_scr[6]};
                        m_scr = {m_scr[5:0], m_scr[6] ^ m_scr[5]};
                    end
                    post = pre ^ mask;
                end
                m_b1acc ^= post;
                if (line) m_b2acc[sub] ^= pre;
                if (r == 8 && c == COLS - 1) begin
                    m_b1 = m_b1acc; m_b1acc = '0;
                    for (int s = 0; s < N; s++) begin
                        m_b2[s] = m_b2acc[s]; m_b2acc[s] = '0;
                    end
                end
                q_val.push_back(post);
                q_sof.push_back(r == 0 && c == 0);
                q_tag.push_back(tag);
            end
        end
    endtask

    initial begin
        #(200000 * 8);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got 00 expected 01");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int s = 0; s < N; s++) begin m_b2[s] = '0; m_b2acc[s] = '0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(out_byte === 8'h00, "R12 reset byte", out_byte, 8'h00);
        check(out_sof === 1'b0, "R12 reset sof", {7'b0, out_sof}, 8'h00);
        send_frame(0, 6'h3F,      1'b0, 1'b0, 1'b0, -1); // R1 R3 R5 baseline
        send_frame(1, 6'h3F,      1'b0, 1'b0, 1'b0,  5); // R9 request mid-frame
        send_frame(2, 6'b010101,  1'b1, 1'b0, 1'b0, -1); // R6 fill ones, R9 applied
        send_frame(3, 6'h00,      1'b0, 1'b0, 1'b1, -1); // R10, R2 inhibited
        send_frame(4, 6'h3F,      1'b0, 1'b1, 1'b0, -1); // R11 line AIS
        send_frame(5, 6'h3F,      1'b1, 1'b0, 1'b0, -1); // R8 parity over AIS frame
        repeat (3) @(posedge clk);
        #3;
        check(q_val.size() == 0, "R12 drain", 8'(q_val.size()), 8'h00);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule